// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider Controller

This block is the digital back end of a clock synthesizer. A fast oscillator-rate clock (nominally 625 MHz) feeds two output banks, A and B. Each bank has a set of true/complement output pairs, and each bank runs its own post-divider of 4 or 5. A 2-bit frequency code picks the two ratios together. One code parks bank B at a static level. A bypass control feeds the chosen reference clock into the post-dividers in place of the oscillator clock. A buffered copy of the chosen reference is available on a separate output, which has its own active-low drive enable.

The active-high master reset clears both dividers asynchronously and forces every bank output low. When it is released, the dividers start at the next edge of the divider clock. Each bank's divider is a small state machine whose state is its active mode. The states are `MODE_HELD` (output parked), `MODE_DIV4` and `MODE_DIV5`. There is one transition, the wrap transition. At the wrap point of the current mode, the machine takes the mode that the frequency code requests. `MODE_HELD` wraps on every clock, so it leaves at once when asked. The divide-by-5 mode adds a falling-edge stage so that its output is high for 2.5 input periods.

Top module: `dual_bank_clk_div`

## Requirements
- R1: Frequency code `freq_code` sets the ratios as follows: 2'b00 gives A /5 and B /5; 2'b01 gives A /5 and B /4; 2'b11 gives A /4 and B /4, relative to the divider clock.
- R2: With `freq_code` = 2'b10, bank A divides by 5 and bank B is parked: every `bank_b_p` bit is 0 and every `bank_b_n` bit is 1.
- R3: Outside reset, each `_n` output is the exact inverse of its `_p` output, and all pairs of a bank carry the same waveform.
- R4: In the divide-by-5 mode, the output is high for 2.5 divider-clock periods of each 5. The divide-by-4 mode is high for 2 of 4.
- R5: A change of `freq_code` takes effect only at the wrap point of the running mode. No high pulse shorter than 2 divider-clock periods appears.
- R6: With `pll_skip` = 1, the dividers are clocked by the selected reference, so each bank outputs reference/ratio.
- R7: `ref_pick` = 0 selects `xtal_clk` and `ref_pick` = 1 selects `refin_clk`. This selection applies to both `ref_out` and the bypass path.
- R8: With `ref_oe_n` = 1, `ref_out_oe` is 0 (pad in high impedance) and `ref_out` is held 0. With `ref_oe_n` = 0, `ref_out_oe` is 1 and `ref_out` follows the selected reference.
- R9: While `mrst_oe` = 1, every bank output (`_p` and `_n`) is 0 without waiting for a clock edge, and no edges appear. After release, the dividers run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator-rate clock |
| xtal_clk | input | 1 | Reference from the crystal path |
| refin_clk | input | 1 | Reference from the single-ended input |
| ref_pick | input | 1 | Reference choice: 0 crystal path, 1 single-ended input |
| pll_skip | input | 1 | 1 clocks the dividers from the reference |
| freq_code | input | 2 | Ratio selection code for both banks |
| mrst_oe | input | 1 | High: reset dividers, outputs low; low: run |
| ref_oe_n | input | 1 | Active-low reference output enable |
| bank_a_p | output | PAIRS | Bank A true outputs |
| bank_a_n | output | PAIRS | Bank A complement outputs |
| bank_b_p | output | PAIRS | Bank B true outputs |
| bank_b_n | output | PAIRS | Bank B complement outputs |
| ref_out | output | 1 | Reference passthrough data |
| ref_out_oe | output | 1 | Drive enable for the reference pad |

## Verification
After a code change, a ratio change is due within one full period of the old mode, which is at most 5 divider clocks. The bench therefore waits at least 100 ns, or 1 µs in bypass, before it opens an edge-counting window. It then compares counts with a tolerance of one edge. Reset, complement and reference-output behaviour are combinational or asynchronous and are due immediately. The bench samples them 1 to 2 ns after the stimulus. Duty-cycle and pulse-width checks sample 2 ns after every oscillator edge, at half-period resolution. At that resolution, a divide-by-5 high phase spans exactly 5 samples and a divide-by-4 high phase spans exactly 4.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int NUM_BANKS = 2;
    localparam int RATIO_LO  = 4;
    localparam int RATIO_HI  = 5;

    typedef enum logic [1:0] {
        MODE_HELD = 2'd0,
        MODE_DIV4 = 2'd1,
        MODE_DIV5 = 2'd2
    } div_mode_e;

    // Ratio table: bank A uses the low ratio only for code 3.
    // Bank B: 0 -> high, 1 -> low, 2 -> parked, 3 -> low.
    function automatic div_mode_e decode_mode(input logic [1:0] code, input logic is_b);
        div_mode_e m;
        if (!is_b) begin
            m = (code == 2'b11) ? MODE_DIV4 : MODE_DIV5;
        end else begin
            unique case (code)
                2'b00:   m = MODE_DIV5;
                2'b10:   m = MODE_HELD;
                default: m = MODE_DIV4;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/ref_clock_path.sv
module ref_clock_path (
    input  logic vco_clk,
    input  logic xtal_clk,
    input  logic refin_clk,
    input  logic ref_pick,
    input  logic pll_skip,
    input  logic ref_oe_n,
    output logic div_clk,
    output logic ref_out,
    output logic ref_out_oe
);

    logic ref_clk;

    always_comb begin
        ref_clk    = ref_pick ? refin_clk : xtal_clk;
        div_clk    = pll_skip ? ref_clk : vco_clk;
        ref_out_oe = ~ref_oe_n;
        ref_out    = ref_clk & ~ref_oe_n;
    end

endmodule

// File: rtl/bank_divider.sv
module bank_divider
    import clkdiv_pkg::*;
#(
    parameter int PAIRS = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  div_mode_e        mode_req,
    output logic [PAIRS-1:0] true_o,
    output logic [PAIRS-1:0] comp_o
);

    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(RATIO_LO - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(RATIO_HI - 1);
    localparam logic [CNT_W-1:0] HIGH_N  = CNT_W'(RATIO_LO / 2);

    div_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             rise_bit;
    logic             fall_q;
    logic             wave;

    // Wrap point of the running mode
    always_comb begin
        wrap = 1'b1;
        unique case (mode_q)
            MODE_HELD: wrap = 1'b1;
            MODE_DIV4: wrap = (cnt_q == LAST_LO);
            MODE_DIV5: wrap = (cnt_q == LAST_HI);
            default:   wrap = 1'b1;
        endcase
    end

    // State register: mode and phase count
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            mode_q <= MODE_HELD;
            cnt_q  <= '0;
        end else if (wrap) begin
            mode_q <= mode_req;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Half-period extension stage for the odd ratio
    always_ff @(negedge clk or posedge rst) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= rise_bit;
    end

    // Output process
    always_comb begin
        rise_bit = 1'b0;
        wave     = 1'b0;
        unique case (mode_q)
            MODE_HELD: begin
                rise_bit = 1'b0;
                wave     = 1'b0;
            end
            MODE_DIV4: begin
                rise_bit = (cnt_q < HIGH_N);
                wave     = rise_bit;
            end
            MODE_DIV5: begin
                rise_bit = (cnt_q < HIGH_N);
                wave     = rise_bit | fall_q;
            end
            default: begin
                rise_bit = 1'b0;
                wave     = 1'b0;
            end
        endcase
    end

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign true_o[i] = wave & ~rst;
        assign comp_o[i] = ~wave & ~rst;
    end

    // A new mode always starts at phase zero
    assert_mode_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> (cnt_q == '0));

    // Phase count never passes the largest ratio
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= LAST_HI));

    // A parked mode holds phase zero
    assert_held_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_HELD && $past(mode_q) == MODE_HELD) |-> (cnt_q == '0));

endmodule

// File: rtl/dual_bank_clk_div.sv
module dual_bank_clk_div
    import clkdiv_pkg::*;
#(
    parameter int PAIRS = 2,
    parameter int CNT_W = 3
) (
    input  logic             vco_clk,
    input  logic             xtal_clk,
    input  logic             refin_clk,
    input  logic             ref_pick,
    input  logic             pll_skip,
    input  logic [1:0]       freq_code,
    input  logic             mrst_oe,
    input  logic             ref_oe_n,
    output logic [PAIRS-1:0] bank_a_p,
    output logic [PAIRS-1:0] bank_a_n,
    output logic [PAIRS-1:0] bank_b_p,
    output logic [PAIRS-1:0] bank_b_n,
    output logic             ref_out,
    output logic             ref_out_oe
);

    logic             div_clk;
    logic [PAIRS-1:0] tru [NUM_BANKS];
    logic [PAIRS-1:0] cmp [NUM_BANKS];

    ref_clock_path u_refpath (
        .vco_clk    (vco_clk),
        .xtal_clk   (xtal_clk),
        .refin_clk  (refin_clk),
        .ref_pick   (ref_pick),
        .pll_skip   (pll_skip),
        .ref_oe_n   (ref_oe_n),
        .div_clk    (div_clk),
        .ref_out    (ref_out),
        .ref_out_oe (ref_out_oe)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic IS_B = (g == 1);
        div_mode_e req;
        assign req = decode_mode(freq_code, IS_B);

        bank_divider #(.PAIRS(PAIRS), .CNT_W(CNT_W)) u_div (
            .clk      (div_clk),
            .rst      (mrst_oe),
            .mode_req (req),
            .true_o   (tru[g]),
            .comp_o   (cmp[g])
        );
    end

    assign bank_a_p = tru[0];
    assign bank_a_n = cmp[0];
    assign bank_b_p = tru[1];
    assign bank_b_n = cmp[1];

    assert_reset_quiet_R9: assert property (@(posedge vco_clk)
        mrst_oe |-> (bank_a_p == '0 && bank_a_n == '0 && bank_b_p == '0 && bank_b_n == '0));

    assert_pair_inverse_R3: assert property (@(posedge vco_clk) disable iff (mrst_oe)
        (bank_a_n == ~bank_a_p) && (bank_b_n == ~bank_b_p));

endmodule

// File: tb/dual_bank_clk_div_test.sv
`timescale 1ns/1ps
module dual_bank_clk_div_test;

    localparam int PAIRS = 2;

    logic             vco_clk = 1'b0;
    logic             xtal_clk = 1'b0;
    logic             refin_clk = 1'b0;
    logic             ref_pick = 1'b0;
    logic             pll_skip = 1'b0;
    logic [1:0]       freq_code = 2'b00;
    logic             mrst_oe = 1'b1;
    logic             ref_oe_n = 1'b1;
    logic [PAIRS-1:0] bank_a_p, bank_a_n, bank_b_p, bank_b_n;
    logic             ref_out, ref_out_oe;

    int checks = 0;
    int failures = 0;
    int edges_a = 0;
    int edges_b = 0;
    int edges_r = 0;

    typedef struct {
        string tag;
        int    exp_a;
        int    exp_b;
        int    tol;
        int    win_ns;
    } item_t;

    item_t sb_q[$];

    always #5  vco_clk   = ~vco_clk;
    always #40 xtal_clk  = ~xtal_clk;
    always #60 refin_clk = ~refin_clk;

    always @(posedge bank_a_p[0]) edges_a++;
    always @(posedge bank_b_p[0]) edges_b++;
    always @(posedge ref_out)     edges_r++;

    dual_bank_clk_div #(.PAIRS(PAIRS), .CNT_W(3)) uut (
        .vco_clk    (vco_clk),
        .xtal_clk   (xtal_clk),
        .refin_clk  (refin_clk),
        .ref_pick   (ref_pick),
        .pll_skip   (pll_skip),
        .freq_code  (freq_code),
        .mrst_oe    (mrst_oe),
        .ref_oe_n   (ref_oe_n),
        .bank_a_p   (bank_a_p),
        .bank_a_n   (bank_a_n),
        .bank_b_p   (bank_b_p),
        .bank_b_n   (bank_b_n),
        .ref_out    (ref_out),
        .ref_out_oe (ref_out_oe)
    );

    task automatic check(input string req, input int act, input int exp, input int tol);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard
    task automatic expect_rates(input string tag, input int ea, input int eb,
                                input int tol, input int win_ns);
        item_t it;
        it.tag = tag; it.exp_a = ea; it.exp_b = eb; it.tol = tol; it.win_ns = win_ns;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // Monitor side: count edges over the window and compare
    initial begin
        forever begin
            item_t it;
            int a0, b0;
            wait (sb_q.size() > 0);
            it = sb_q[0];
            a0 = edges_a;
            b0 = edges_b;
            #(it.win_ns);
            check({it.tag, " bank A"}, edges_a - a0, it.exp_a, it.tol);
            check({it.tag, " bank B"}, edges_b - b0, it.exp_b, it.tol);
            void'(sb_q.pop_front());
        end
    end

    task automatic half_step();
        if (vco_clk) @(negedge vco_clk); else @(posedge vco_clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hi_a, hi_b, bad, run_a, run_b, min_a, min_b, max_a, r0;
        bit seen_lo_a, seen_lo_b;
        logic [1:0] seq [4];

        // Reset state
        #203;
        check("R9 reset a_p", int'(bank_a_p), 0, 0);
        check("R9 reset a_n", int'(bank_a_n), 0, 0);
        check("R9 reset b_p", int'(bank_b_p), 0, 0);
        check("R9 reset b_n", int'(bank_b_n), 0, 0);
        check("R8 default ref_out_oe", int'(ref_out_oe), 0, 0);
        expect_rates("R9 held in reset", 0, 0, 0, 1000);

        @(negedge vco_clk);
        mrst_oe = 1'b0;

        // R1 ratio table
        freq_code = 2'b00; #100; expect_rates("R1 code00", 200, 200, 1, 10000);
        freq_code = 2'b01; #100; expect_rates("R1 code01", 200, 250, 1, 10000);
        freq_code = 2'b11; #100; expect_rates("R1 code11", 250, 250, 1, 10000);

        // R2 parked bank B
        freq_code = 2'b10; #100; expect_rates("R2 code10", 200, 0, 0, 10000);
        check("R2 b_p parked low", int'(bank_b_p), 0, 0);
        check("R2 b_n parked high", int'(bank_b_n), 3, 0);

        // R3 complement and pair alignment
        freq_code = 2'b01; #100;
        bad = 0;
        for (int i = 0; i < 400; i++) begin
            half_step();
            if (bank_a_n != ~bank_a_p || bank_b_n != ~bank_b_p) bad++;
            if (bank_a_p[0] != bank_a_p[1] || bank_b_p[0] != bank_b_p[1]) bad++;
        end
        check("R3 inverse/aligned mismatches", bad, 0, 0);

        // R4 duty cycle: code01 gives A /5 and B /4
        hi_a = 0; hi_b = 0;
        for (int i = 0; i < 2000; i++) begin
            half_step();
            hi_a += int'(bank_a_p[0]);
            hi_b += int'(bank_b_p[0]);
        end
        check("R4 div5 high halves", hi_a, 1000, 3);
        check("R4 div4 high halves", hi_b, 1000, 3);

        // R5 code changes at arbitrary phase: no runt pulse
        seq[0] = 2'b00; seq[1] = 2'b11; seq[2] = 2'b10; seq[3] = 2'b01;
        run_a = 0; run_b = 0; min_a = 99; min_b = 99; max_a = 0;
        seen_lo_a = 1'b0; seen_lo_b = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (i % 37 == 0) freq_code = seq[(i / 37) % 4];
            half_step();
            if (bank_a_p[0]) run_a++;
            else begin
                if (seen_lo_a && run_a > 0) begin
                    if (run_a < min_a) min_a = run_a;
                    if (run_a > max_a) max_a = run_a;
                end
                seen_lo_a = 1'b1; run_a = 0;
            end
            if (bank_b_p[0]) run_b++;
            else begin
                if (seen_lo_b && run_b > 0 && run_b < min_b) min_b = run_b;
                seen_lo_b = 1'b1; run_b = 0;
            end
        end
        check("R5 bank A shortest high", (min_a >= 4) ? 1 : 0, 1, 0);
        check("R5 bank A longest high", (max_a <= 5) ? 1 : 0, 1, 0);
        check("R5 bank B shortest high", (min_b >= 4) ? 1 : 0, 1, 0);

        // R6 / R7 bypass through the post-dividers
        pll_skip = 1'b1; ref_pick = 1'b0; freq_code = 2'b00; #1000;
        expect_rates("R6 R7 bypass xtal code00", 30, 30, 1, 12000);
        freq_code = 2'b11; #1000;
        expect_rates("R6 bypass xtal code11", 37, 37, 1, 12000);
        ref_pick = 1'b1; freq_code = 2'b01; #1000;
        expect_rates("R6 R7 bypass refin code01", 20, 25, 1, 12000);

        // R7 / R8 reference passthrough
        ref_oe_n = 1'b0; ref_pick = 1'b0; #2;
        check("R8 enabled ref_out_oe", int'(ref_out_oe), 1, 0);
        r0 = edges_r; #8000;
        check("R7 ref_out xtal edges", edges_r - r0, 100, 1);
        ref_pick = 1'b1; #200;
        r0 = edges_r; #8000;
        check("R7 ref_out refin edges", edges_r - r0, 66, 1);
        ref_oe_n = 1'b1; #2;
        check("R8 disabled ref_out_oe", int'(ref_out_oe), 0, 0);
        r0 = edges_r; #2000;
        check("R8 disabled ref_out edges", edges_r - r0, 0, 0);
        check("R8 disabled ref_out level", int'(ref_out), 0, 0);

        // R9 asynchronous reset while running
        pll_skip = 1'b0; freq_code = 2'b00; #200;
        @(posedge vco_clk); #3;
        mrst_oe = 1'b1; #1;
        check("R9 async a_p/b_p", int'({bank_a_p, bank_b_p}), 0, 0);
        check("R9 async a_n/b_n", int'({bank_a_n, bank_b_n}), 0, 0);
        expect_rates("R9 reset window", 0, 0, 0, 2000);
        @(negedge vco_clk);
        mrst_oe = 1'b0; #100;
        expect_rates("R9 after release", 200, 200, 1, 10000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule